// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block resolves one group of eight interrupt request lines into a single winning line number. Each line is captured into a request register. A per-line trigger-mode bit picks how it is captured: a level line copies its input, and an edge line latches on a rising input. Pending requests are filtered by a mask register. The survivors are then searched in a circular priority order whose starting point is a programmable rotation offset. The best candidate is granted only if it outranks every line currently recorded as in service.

The surrounding controller owns the command decoding. It loads the mask, in-service, offset and trigger-mode registers through simple write-enable/data pairs, and it clears latched edge requests once they are acknowledged. The unit is built as either the master or the slave of a cascaded pair. The choice changes two things: which trigger-mode bits may be set, and whether the special nested mode may leave the cascade line's in-service bit out of the comparison. The grant is a purely combinational function of the registered state and of the nested-mode input.

Top module: `irq_resolver`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level) has its request bit equal to its input as sampled at the most recent clock edge, so dropping the input withdraws the request one edge later.
- R2: A line whose trigger-mode bit is 0 (edge) sets its request bit at an edge where the input is 1 and was 0 at the previous edge. The bit stays set after the input falls. Only its `req_clr` bit or reset clears it, and a new rising input wins over a clear in the same cycle. `req_clr` has no effect on level lines.
- R3: Line L has priority index (L - offset) mod 8, and a smaller index means a higher priority. With several lines pending, `irq_line` is the pending line with the smallest index.
- R4: A request whose mask bit is 1 takes no part in the search.
- R5: The best unmasked request is granted only when its priority index is strictly smaller than the index of the highest-priority in-service bit. An equal or larger index gives no grant, and no in-service bits counts as index 8.
- R6: In the master build with `nest_en` high, in-service bit 2 (the cascade line) is ignored in the R5 comparison. The slave build never ignores it.
- R7: A trigger-mode write stores the written byte ANDed with a fixed writable mask: 0xF8 in the master build and 0xDE in the slave build. Bits outside that mask stay 0 (edge).
- R8: Synchronous active-high reset clears the request, previous-level, mask and in-service registers and the offset. It leaves the trigger-mode bits unchanged, and a trigger-mode write is accepted even while reset is high.
- R9: A captured request or a register write shows at the outputs straight after the clock edge that stores it. A change of `nest_en` shows within the same cycle.
- R10: With no grant, `irq_valid` is 0 and `irq_line` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Interrupt request inputs, one per line |
| req_clr | input | 8 | Per-line clear of latched edge requests |
| trig_we | input | 1 | Write enable for the trigger-mode register |
| trig_wd | input | 8 | Trigger-mode write data, 1 = level, 0 = edge |
| mask_we | input | 1 | Write enable for the mask register |
| mask_wd | input | 8 | Mask write data, 1 = line masked |
| isr_we | input | 1 | Write enable for the in-service register |
| isr_wd | input | 8 | In-service write data |
| ofs_we | input | 1 | Write enable for the rotation offset |
| ofs_wd | input | 3 | Rotation offset, the line that has priority index 0 |
| nest_en | input | 1 | Special nested mode, effective in the master build only |
| irq_valid | output | 1 | A line is granted |
| irq_line | output | 3 | Number of the granted line |

## Verification
The bench aims at these cases:
- Equal priority between the best request and the best in-service line. A design that compared with less-or-equal would grant a line that is already being serviced.
- Rotation offsets that make the search wrap past line 7. A design that forgot the modulo would pick the numerically lowest line.
- A falling input on an edge line next to a level line. Mixing up the two modes either loses a latched request or leaves a withdrawn one standing.
- Writes of 0xFF to the trigger-mode register in both builds, a reset that must keep trigger modes, and the cascade-bit exclusion that applies only to the master. Each of these would show as a wrong or missing grant.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    localparam int unsigned NUM_LINES = 8;
    localparam int unsigned LINE_W    = $clog2(NUM_LINES);
    localparam int unsigned PRIO_W    = LINE_W + 1;

    // line whose in-service bit the master may skip in special nested mode
    localparam int unsigned CASCADE_LINE = 2;

    localparam logic [NUM_LINES-1:0] MASTER_TRIG_WMASK = 8'hF8;
    localparam logic [NUM_LINES-1:0] SLAVE_TRIG_WMASK  = 8'hDE;

    typedef logic [NUM_LINES-1:0] line_vec_t;
    typedef logic [LINE_W-1:0]    line_idx_t;
    typedef logic [PRIO_W-1:0]    prio_t;

    localparam prio_t PRIO_NONE = prio_t'(NUM_LINES);

    typedef struct packed {
        logic      valid;
        line_idx_t line;
    } grant_t;

    // Reorder a per-line vector so bit p holds line (p + ofs) mod NUM_LINES.
    function automatic line_vec_t rotate_to_prio(line_vec_t v, line_idx_t ofs);
        line_vec_t r;
        for (int p = 0; p < NUM_LINES; p++) begin
            r[p] = v[line_idx_t'(p) + ofs];
        end
        return r;
    endfunction

    function automatic line_idx_t prio_to_line(prio_t p, line_idx_t ofs);
        return line_idx_t'(p[LINE_W-1:0] + ofs);
    endfunction

endpackage

// File: rtl/irq_capture.sv
module irq_capture
    import irq_res_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t req_in,
    input  line_vec_t level_mode,
    input  line_vec_t req_clr,
    output line_vec_t req_q,
    output line_vec_t prev_q
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic req_nxt;

        always_comb begin
            if (level_mode[i]) begin
                req_nxt = req_in[i];
            end else if (req_in[i] && !prev_q[i]) begin
                req_nxt = 1'b1;
            end else if (req_clr[i]) begin
                req_nxt = 1'b0;
            end else begin
                req_nxt = req_q[i];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                req_q[i]  <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                req_q[i]  <= req_nxt;
                prev_q[i] <= req_in[i];
            end
        end
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_res_pkg::*;
(
    input  line_vec_t vec,
    output prio_t     prio
);

    // smallest set index wins; PRIO_NONE when the vector is empty
    always_comb begin
        prio = PRIO_NONE;
        for (int p = NUM_LINES - 1; p >= 0; p--) begin
            if (vec[p]) begin
                prio = prio_t'(p);
            end
        end
    end

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_res_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_LINES-1:0]   req_in,
    input  logic [NUM_LINES-1:0]   req_clr,
    input  logic                   trig_we,
    input  logic [NUM_LINES-1:0]   trig_wd,
    input  logic                   mask_we,
    input  logic [NUM_LINES-1:0]   mask_wd,
    input  logic                   isr_we,
    input  logic [NUM_LINES-1:0]   isr_wd,
    input  logic                   ofs_we,
    input  logic [LINE_W-1:0]      ofs_wd,
    input  logic                   nest_en,
    output logic                   irq_valid,
    output logic [LINE_W-1:0]      irq_line
);

    localparam line_vec_t TRIG_WMASK = IS_MASTER ? MASTER_TRIG_WMASK : SLAVE_TRIG_WMASK;
    localparam line_vec_t CASCADE_BIT = line_vec_t'(1) << CASCADE_LINE;

    line_vec_t trig_q = '0;
    line_vec_t mask_q;
    line_vec_t isr_q;
    line_idx_t ofs_q;
    line_vec_t irr_q;
    line_vec_t last_q;

    line_vec_t pending;
    line_vec_t isr_eff;
    line_vec_t pend_rot;
    line_vec_t isr_rot;
    prio_t     pend_prio;
    prio_t     cur_prio;
    grant_t    grant;

    // trigger modes survive reset
    always_ff @(posedge clk) begin
        if (trig_we) begin
            trig_q <= trig_wd & TRIG_WMASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            isr_q  <= '0;
            ofs_q  <= '0;
        end else begin
            if (mask_we) mask_q <= mask_wd;
            if (isr_we)  isr_q  <= isr_wd;
            if (ofs_we)  ofs_q  <= ofs_wd;
        end
    end

    irq_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .req_in     (req_in),
        .level_mode (trig_q),
        .req_clr    (req_clr),
        .req_q      (irr_q),
        .prev_q     (last_q)
    );

    assign pending = irr_q & ~mask_q;

    if (IS_MASTER) begin : g_nest
        assign isr_eff = nest_en ? (isr_q & ~CASCADE_BIT) : isr_q;
    end else begin : g_no_nest
        assign isr_eff = isr_q;
    end

    assign pend_rot = rotate_to_prio(pending, ofs_q);
    assign isr_rot  = rotate_to_prio(isr_eff, ofs_q);

    irq_prio_enc u_enc_pend (
        .vec  (pend_rot),
        .prio (pend_prio)
    );

    irq_prio_enc u_enc_isr (
        .vec  (isr_rot),
        .prio (cur_prio)
    );

    always_comb begin
        grant = '0;
        if (pend_prio < cur_prio) begin
            grant.valid = 1'b1;
            grant.line  = prio_to_line(pend_prio, ofs_q);
        end
    end

    assign irq_valid = grant.valid;
    assign irq_line  = grant.line;

endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk
    import irq_res_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input logic      clk,
    input logic      rst,
    input line_vec_t req_in,
    input line_vec_t req_clr,
    input logic      nest_en,
    input logic      irq_valid,
    input line_idx_t irq_line,
    input line_vec_t irr_q,
    input line_vec_t last_q,
    input line_vec_t trig_q,
    input line_vec_t mask_q,
    input line_vec_t isr_q
);

    // R1: level lines mirror the previously sampled input
    p_level_follow_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((irr_q ^ $past(req_in)) & $past(trig_q)) == '0);

    // R2: a latched edge request only drops through an explicit clear
    p_edge_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (~$past(trig_q) & $past(irr_q) & ~$past(req_clr) & ~irr_q) == '0);

    // R2: an edge request only appears after a rising input
    p_edge_rise_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (~$past(trig_q) & irr_q & ~$past(irr_q)
                  & ~($past(req_in) & ~$past(last_q))) == '0);

    // R4: a masked line is never granted
    p_no_masked_grant_r4: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> !mask_q[irq_line]);

    // R3: the granted line holds a request
    p_grant_has_req_r3: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> irr_q[irq_line]);

    // R5: a line already in service is not granted again (bar the nested exception)
    p_not_in_service_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !(IS_MASTER && nest_en && irq_line == line_idx_t'(CASCADE_LINE)))
        |-> !isr_q[irq_line]);

    // R10: no grant means line number zero
    p_idle_line_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !irq_valid |-> irq_line == '0);

endmodule

bind irq_resolver irq_resolver_chk #(.IS_MASTER(IS_MASTER)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_in    (req_in),
    .req_clr   (req_clr),
    .nest_en   (nest_en),
    .irq_valid (irq_valid),
    .irq_line  (irq_line),
    .irr_q     (irr_q),
    .last_q    (last_q),
    .trig_q    (trig_q),
    .mask_q    (mask_q),
    .isr_q     (isr_q)
);

// File: tb/irq_resolver_test.sv
module irq_resolver_test;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 3000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_in = '0, req_clr = '0;
    logic       trig_we = 1'b0, mask_we = 1'b0, isr_we = 1'b0, ofs_we = 1'b0;
    logic [7:0] trig_wd = '0, mask_wd = '0, isr_wd = '0;
    logic [2:0] ofs_wd = '0;
    logic       nest_en = 1'b0;
    logic       v_m, v_s;
    logic [2:0] l_m, l_s;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_resolver #(.IS_MASTER(1'b1)) uut (
        .clk(clk), .rst(rst), .req_in(req_in), .req_clr(req_clr),
        .trig_we(trig_we), .trig_wd(trig_wd), .mask_we(mask_we), .mask_wd(mask_wd),
        .isr_we(isr_we), .isr_wd(isr_wd), .ofs_we(ofs_we), .ofs_wd(ofs_wd),
        .nest_en(nest_en), .irq_valid(v_m), .irq_line(l_m)
    );

    irq_resolver #(.IS_MASTER(1'b0)) uut_slave (
        .clk(clk), .rst(rst), .req_in(req_in), .req_clr(req_clr),
        .trig_we(trig_we), .trig_wd(trig_wd), .mask_we(mask_we), .mask_wd(mask_wd),
        .isr_we(isr_we), .isr_wd(isr_wd), .ofs_we(ofs_we), .ofs_wd(ofs_wd),
        .nest_en(nest_en), .irq_valid(v_s), .irq_line(l_s)
    );

    // reference state per build: index 0 master, 1 slave
    logic [7:0] m_irr [2];
    logic [7:0] m_last[2];
    logic [7:0] m_trig[2];
    logic [7:0] m_mask[2];
    logic [7:0] m_isr [2];
    logic [2:0] m_ofs [2];

    initial begin
        for (int u = 0; u < 2; u++) begin
            m_trig[u] = '0; m_irr[u] = '0; m_last[u] = '0;
            m_mask[u] = '0; m_isr[u] = '0; m_ofs[u] = '0;
        end
    end

    always @(posedge clk) begin
        for (int u = 0; u < 2; u++) begin
            logic [7:0] nirr;
            nirr = m_irr[u];
            for (int i = 0; i < 8; i++) begin
                if (m_trig[u][i])                          nirr[i] = req_in[i];
                else if (req_in[i] && !m_last[u][i])       nirr[i] = 1'b1;
                else if (req_clr[i])                       nirr[i] = 1'b0;
            end
            if (trig_we) m_trig[u] = trig_wd & ((u == 0) ? 8'hF8 : 8'hDE);
            if (rst) begin
                m_irr[u] = '0; m_last[u] = '0; m_mask[u] = '0; m_isr[u] = '0; m_ofs[u] = '0;
            end else begin
                m_irr[u] = nirr; m_last[u] = req_in;
                if (mask_we) m_mask[u] = mask_wd;
                if (isr_we)  m_isr[u]  = isr_wd;
                if (ofs_we)  m_ofs[u]  = ofs_wd;
            end
        end
    end

    function automatic int first_prio(logic [7:0] v, logic [2:0] ofs);
        for (int p = 0; p < 8; p++) begin
            if (v[3'(p) + ofs]) return p;
        end
        return 8;
    endfunction

    function automatic logic [3:0] expect_grant(int u, logic nest);
        logic [7:0] isr_e;
        int pp, cp;
        isr_e = m_isr[u];
        if (u == 0 && nest) isr_e[2] = 1'b0;
        pp = first_prio(m_irr[u] & ~m_mask[u], m_ofs[u]);
        cp = first_prio(isr_e, m_ofs[u]);
        if (pp < cp) return {1'b1, 3'(pp) + m_ofs[u]};
        return 4'b0000;
    endfunction

    task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b line=%0d, expected valid=%0b line=%0d",
                     tag, got[3], got[2:0], exp[3], exp[2:0]);
        end
    endtask

    task automatic check_model(string tag);
        check({tag, " master"}, {v_m, l_m}, expect_grant(0, nest_en));
        check({tag, " slave"},  {v_s, l_s}, expect_grant(1, nest_en));
    endtask

    // one clock edge, then settle away from it and drop one-shot inputs
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
        trig_we = 0; mask_we = 0; isr_we = 0; ofs_we = 0; req_clr = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        tick(); tick();
        rst = 0;
        tick();
        // R8 R10: reset state
        check("R8 reset master", {v_m, l_m}, 4'b0000);
        check("R10 idle slave",  {v_s, l_s}, 4'b0000);

        // R2 edge latch and clear, R9 timing
        req_in = 8'h20; tick();
        check("R9 R2 edge captured", {v_m, l_m}, 4'b1101);
        req_in = 8'h00; tick();
        check("R2 edge held after fall", {v_s, l_s}, 4'b1101);
        req_clr = 8'h20; tick();
        check("R2 edge cleared", {v_m, l_m}, 4'b0000);

        // R7 R1: write all ones, master keeps line0 edge, slave keeps 0 and 5 edge
        trig_we = 1; trig_wd = 8'hFF; tick();
        req_in = 8'h01; tick();
        req_in = 8'h00; tick();
        check("R7 master line0 stays edge", {v_m, l_m}, 4'b1000);
        req_clr = 8'h01; tick();
        req_in = 8'h08; tick();
        check("R1 level line3 up", {v_m, l_m}, 4'b1011);
        req_in = 8'h00; tick();
        check("R1 level line3 withdrawn", {v_m, l_m}, 4'b0000);
        req_in = 8'h20; tick();
        req_in = 8'h00; tick();
        check("R1 master line5 level gone", {v_m, l_m}, 4'b0000);
        check("R7 slave line5 stays edge", {v_s, l_s}, 4'b1101);
        req_clr = 8'h20; trig_we = 1; trig_wd = 8'h00; tick();

        // R3 rotation
        req_in = 8'h42; tick();
        req_in = 8'h00; tick();
        ofs_we = 1; ofs_wd = 3'd4; tick();
        check("R3 offset 4", {v_m, l_m}, 4'b1110);
        ofs_we = 1; ofs_wd = 3'd7; tick();
        check("R3 offset 7 wraps", {v_m, l_m}, 4'b1001);
        ofs_we = 1; ofs_wd = 3'd2; tick();
        check("R3 offset 2", {v_s, l_s}, 4'b1110);
        ofs_we = 1; ofs_wd = 3'd0; tick();
        check("R3 offset 0", {v_m, l_m}, 4'b1001);

        // R5 strict comparison
        isr_we = 1; isr_wd = 8'h02; tick();
        check("R5 equal priority blocked", {v_m, l_m}, 4'b0000);
        isr_we = 1; isr_wd = 8'h40; tick();
        check("R5 lower in-service allows", {v_m, l_m}, 4'b1001);

        // R6 nested exclusion of the cascade bit
        isr_we = 1; isr_wd = 8'h04; req_clr = 8'h02; tick();
        check("R6 nest off master blocked", {v_m, l_m}, 4'b0000);
        nest_en = 1; #1;
        check("R6 nest on master grants", {v_m, l_m}, 4'b1110);
        check("R6 nest on slave blocked", {v_s, l_s}, 4'b0000);
        nest_en = 0;

        // R4 masking
        isr_we = 1; isr_wd = 8'h00; req_in = 8'h08; tick();
        req_in = 8'h00; tick();
        check("R4 unmasked line3", {v_m, l_m}, 4'b1011);
        mask_we = 1; mask_wd = 8'h08; tick();
        check("R4 line3 masked", {v_m, l_m}, 4'b1110);
        mask_we = 1; mask_wd = 8'h48; tick();
        check("R4 all masked", {v_m, l_m}, 4'b0000);

        // R8 reset keeps trigger modes
        trig_we = 1; trig_wd = 8'hFF; tick();
        rst = 1; tick(); rst = 0;
        check("R8 reset clears", {v_m, l_m}, 4'b0000);
        req_in = 8'h08; tick();
        check("R8 after reset line3", {v_m, l_m}, 4'b1011);
        req_in = 8'h00; tick();
        check("R8 trigger mode kept", {v_m, l_m}, 4'b0000);
        check_model("R1 directed end");

        // random phase, R1..R10 against the reference
        void'($urandom(32'h5EED_1234));
        for (int n = 0; n < RAND_CYCLES; n++) begin
            req_in  = 8'($urandom);
            req_clr = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
            trig_we = (($urandom % 16) == 0); trig_wd = 8'($urandom);
            mask_we = (($urandom % 6) == 0);  mask_wd = 8'($urandom) & 8'($urandom);
            isr_we  = (($urandom % 6) == 0);  isr_wd  = 8'($urandom) & 8'($urandom);
            ofs_we  = (($urandom % 5) == 0);  ofs_wd  = 3'($urandom);
            nest_en = 1'($urandom);
            rst     = (($urandom % 200) == 0);
            @(posedge clk);
            @(negedge clk);
            #1;
            check_model("R3 R5 random");
        end
        rst = 0;
        finish_run();
    end

endmodule